// File: doc/BRIEF.md
# Open-Page DRAM Access Timer

This block stands in front of a stream of word requests and works out how long a single-bank DRAM with an open-page policy takes to serve each one. It stores which page is open. A request that falls in that page is served after the short same-page latency. Any other request, including the first one after reset, pays the full random latency, and that latency includes a row-activate phase. No data is stored. The block only times the accesses, and each response returns the address and the read/write flag of the request it completes.

Three statistics counters run beside the timer. The first counts page conflicts, meaning accepted requests whose page differs from the page of the previous request. The second counts access cycles, and the third counts the bytes moved. Dividing the bytes by the cycles gives the bandwidth of an address stream. A synchronous clear zeroes all three counters and leaves the open page as it is.

The controller is a four-state machine. ST_IDLE raises ready. When a request is accepted, ST_IDLE goes to ST_ACCESS if the page hits and to ST_ACTIVATE if it misses. ST_ACTIVATE lasts T_ACT cycles and then moves to ST_ACCESS for the rest of the random latency. ST_ACCESS counts down its load value and then moves to ST_RESPOND. ST_RESPOND holds the response pulse for one cycle and then returns to ST_IDLE.

Top module: `dram_page_timer`

## Requirements
- R1: The page number of a request is its word address shifted right by log2(PAGE_WORDS), using all upper address bits. Two addresses hit the same page only if these numbers are equal.
- R2: After reset, req_ready is 1, rsp_valid is 0 and all counters are 0. No page is open, so the first accepted request takes T_RANDOM cycles and counts no conflict.
- R3: A request whose page differs from the open page takes T_RANDOM cycles (default 8). If it is accepted at clock edge k, rsp_valid is 1 for exactly one cycle, between edges k+T_RANDOM and k+T_RANDOM+1.
- R4: A request to the open page takes T_PAGE cycles (default 3), with the same timing rule as R3 but T_PAGE in place of T_RANDOM.
- R5: conflict_cnt increases by 1 for each accepted request whose page differs from the page of the previous accepted request. It changes at no other time.
- R6: req_ready is 0 from the edge that accepts a request until the response cycle has ended. It is 1 in the cycle after the rsp_valid pulse, so at most one request is in progress and requests are served in order.
- R7: cycle_cnt increases by 1 for each cycle spent between acceptance and response, which adds the access latency of every request. It does not count idle cycles or response cycles.
- R8: byte_cnt increases by BYTES_PER_WORD (4) at the edge that ends each response cycle.
- R9: When clr is 1 at a clock edge, all three counters are 0 after that edge, even if an increment falls on the same edge. The open page does not change.
- R10: req_write has no effect on latency or counters. rsp_addr and rsp_write return the address and flag of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the counters |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A request can be accepted this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | One-cycle pulse marking the end of an access |
| rsp_addr | output | ADDR_W | Address of the request being answered |
| rsp_write | output | 1 | Write flag of the request being answered |
| conflict_cnt | output | CNT_W | Number of page changes |
| cycle_cnt | output | CNT_W | Number of access cycles |
| byte_cnt | output | CNT_W | Number of bytes transferred |

## Verification
The properties assume that rst_n is asserted before the first edge of interest and that clr is a clean one-cycle-or-longer level sampled at the edge. They also assume the request stream never holds more than one request in progress. The bench keeps within this by changing req_valid, req_addr and clr only on falling edges. It issues a new request only after it has seen req_ready high, or it holds req_valid high so that the block pulls its own request in. The address streams run sequentially within a page, step over a page boundary, alternate between two pages and differ only in the top address bit. One clear falls on the same edge as an acceptance that would otherwise count a conflict.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVATE,
        ST_ACCESS,
        ST_RESPOND
    } dpt_state_e;

endpackage

// File: rtl/dpt_page_track.sv
module dpt_page_track #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              page_hit,
    output logic              page_change,
    output logic [ADDR_W-1:0] held_addr,
    output logic              held_write
);

    localparam int PAGE_SH = $clog2(PAGE_WORDS);
    localparam int PG_W    = ADDR_W - PAGE_SH;

    logic [PG_W-1:0] req_page;
    logic [PG_W-1:0] open_page_q;
    logic            open_vld_q;
    logic            same_page;

    // page number extraction; a one-word page uses the whole address
    generate
        if (PAGE_SH == 0) begin : g_word_page
            assign req_page = req_addr;
        end else begin : g_multi_page
            assign req_page = req_addr[ADDR_W-1:PAGE_SH];
        end
    endgenerate

    assign same_page   = (req_page == open_page_q);
    assign page_hit    = open_vld_q && same_page;
    assign page_change = accept && open_vld_q && !same_page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_page_q <= '0;
            open_vld_q  <= 1'b0;
            held_addr   <= '0;
            held_write  <= 1'b0;
        end else if (accept) begin
            open_page_q <= req_page;
            open_vld_q  <= 1'b1;
            held_addr   <= req_addr;
            held_write  <= req_write;
        end
    end

endmodule

// File: rtl/dpt_fsm.sv
module dpt_fsm
    import dpt_pkg::*;
#(
    parameter int T_RANDOM = 8,
    parameter int T_PAGE   = 3,
    parameter int T_ACT    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic page_hit,
    output logic accept,
    output logic req_ready,
    output logic rsp_valid,
    output logic busy
);

    localparam int LMAX = (T_RANDOM > T_PAGE) ? T_RANDOM : T_PAGE;
    localparam int CW   = $clog2(LMAX + 1);
    localparam logic [CW-1:0] LD_PAGE = CW'(T_PAGE - 1);
    localparam logic [CW-1:0] LD_ACT  = CW'(T_ACT - 1);
    localparam logic [CW-1:0] LD_REST = CW'(T_RANDOM - T_ACT - 1);

    dpt_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (page_hit) begin
                        state_d = ST_ACCESS;
                        cnt_d   = LD_PAGE;
                    end else begin
                        state_d = ST_ACTIVATE;
                        cnt_d   = LD_ACT;
                    end
                end
            end
            ST_ACTIVATE: begin
                if (cnt_q == '0) begin
                    state_d = ST_ACCESS;
                    cnt_d   = LD_REST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d = ST_RESPOND;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready && req_valid;
        rsp_valid = (state_q == ST_RESPOND);
        busy      = (state_q == ST_ACTIVATE) || (state_q == ST_ACCESS);
    end

endmodule

// File: rtl/dpt_stats.sv
module dpt_stats #(
    parameter int CNT_W          = 32,
    parameter int BYTES_PER_WORD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             page_change,
    input  logic             busy,
    input  logic             done,
    output logic [CNT_W-1:0] conflict_cnt,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic [CNT_W-1:0] byte_cnt
);

    localparam int NCNT = 3;

    logic [NCNT-1:0]  inc_en;
    logic [CNT_W-1:0] step  [NCNT];
    logic [CNT_W-1:0] cnt_q [NCNT];

    assign inc_en  = {done, busy, page_change};
    assign step[0] = CNT_W'(1);
    assign step[1] = CNT_W'(1);
    assign step[2] = CNT_W'(BYTES_PER_WORD);

    generate
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q[i] <= '0;
                end else if (clr) begin
                    cnt_q[i] <= '0;
                end else if (inc_en[i]) begin
                    cnt_q[i] <= cnt_q[i] + step[i];
                end
            end
        end
    endgenerate

    assign conflict_cnt = cnt_q[0];
    assign cycle_cnt    = cnt_q[1];
    assign byte_cnt     = cnt_q[2];

endmodule

// File: rtl/dram_page_timer.sv
module dram_page_timer #(
    parameter int ADDR_W         = 32,
    parameter int PAGE_WORDS     = 64,
    parameter int T_RANDOM       = 8,
    parameter int T_PAGE         = 3,
    parameter int T_ACT          = 1,
    parameter int CNT_W          = 32,
    parameter int BYTES_PER_WORD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic [CNT_W-1:0]  conflict_cnt,
    output logic [CNT_W-1:0]  cycle_cnt,
    output logic [CNT_W-1:0]  byte_cnt
);

    logic accept;
    logic page_hit;
    logic page_change;
    logic busy;

    dpt_page_track #(
        .ADDR_W     (ADDR_W),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .page_hit    (page_hit),
        .page_change (page_change),
        .held_addr   (rsp_addr),
        .held_write  (rsp_write)
    );

    dpt_fsm #(
        .T_RANDOM (T_RANDOM),
        .T_PAGE   (T_PAGE),
        .T_ACT    (T_ACT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .page_hit  (page_hit),
        .accept    (accept),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .busy      (busy)
    );

    dpt_stats #(
        .CNT_W          (CNT_W),
        .BYTES_PER_WORD (BYTES_PER_WORD)
    ) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .page_change  (page_change),
        .busy         (busy),
        .done         (rsp_valid),
        .conflict_cnt (conflict_cnt),
        .cycle_cnt    (cycle_cnt),
        .byte_cnt     (byte_cnt)
    );

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
    parameter int CNT_W          = 32,
    parameter int BYTES_PER_WORD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [CNT_W-1:0] conflict_cnt,
    input logic [CNT_W-1:0] cycle_cnt,
    input logic [CNT_W-1:0] byte_cnt
);

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    no_ready_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R6
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    conflict_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(req_valid && req_ready)) |=> $stable(conflict_cnt));

    // R7
    cycles_hold_when_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (req_ready || rsp_valid)) |=> $stable(cycle_cnt));

    // R8
    bytes_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rsp_valid) |=> (byte_cnt == $past(byte_cnt) + CNT_W'(BYTES_PER_WORD)));

    // R8
    bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rsp_valid) |=> $stable(byte_cnt));

    // R9
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (conflict_cnt == '0 && cycle_cnt == '0 && byte_cnt == '0));

endmodule

bind dram_page_timer dpt_checker #(
    .CNT_W          (CNT_W),
    .BYTES_PER_WORD (BYTES_PER_WORD)
) u_dpt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .conflict_cnt (conflict_cnt),
    .cycle_cnt    (cycle_cnt),
    .byte_cnt     (byte_cnt)
);

// File: tb/tb_dram_page_timer.sv
`timescale 1ns/1ps
module tb_dram_page_timer;

    localparam int AW    = 32;
    localparam int PW    = 64;
    localparam int TR    = 8;
    localparam int TP    = 3;
    localparam int CW    = 32;
    localparam int SHIFT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_ready;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic          rsp_write;
    logic [CW-1:0] conflict_cnt, cycle_cnt, byte_cnt;

    always #5 clk = ~clk;

    dram_page_timer #(
        .ADDR_W(AW), .PAGE_WORDS(PW), .T_RANDOM(TR), .T_PAGE(TP),
        .T_ACT(1), .CNT_W(CW), .BYTES_PER_WORD(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_write(rsp_write),
        .conflict_cnt(conflict_cnt), .cycle_cnt(cycle_cnt), .byte_cnt(byte_cnt)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference model
    int          m_left = 0;
    bit          m_resp = 1'b0;
    bit          m_open = 1'b0;
    longint      m_page = 0;
    longint      m_conf = 0, m_cyc = 0, m_byte = 0;
    logic [AW-1:0] m_addr = '0;
    bit          m_wr = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        longint pg;
        if (m_resp) begin
            m_resp = 1'b0;
            m_byte += 4;
        end else if (m_left > 0) begin
            m_cyc++;
            m_left--;
            if (m_left == 0) m_resp = 1'b1;
        end else if (req_valid) begin
            pg = longint'(req_addr >> SHIFT);
            if (m_open && pg == m_page) m_left = TP;
            else begin
                m_left = TR;
                if (m_open) m_conf++;
            end
            m_page = pg;
            m_open = 1'b1;
            m_addr = req_addr;
            m_wr   = req_write;
        end
        if (clr) begin
            m_conf = 0; m_cyc = 0; m_byte = 0;
        end
    endtask

    task automatic compare_all();
        chk("R6 req_ready", longint'(req_ready), longint'(!m_resp && m_left == 0));
        chk("R3/R4 rsp_valid", longint'(rsp_valid), longint'(m_resp));
        chk("R5 conflict_cnt", longint'(conflict_cnt), m_conf);
        chk("R7 cycle_cnt", longint'(cycle_cnt), m_cyc);
        chk("R8 byte_cnt", longint'(byte_cnt), m_byte);
        if (rsp_valid && m_resp) begin
            chk("R10 rsp_addr", longint'(rsp_addr), longint'(m_addr));
            chk("R10 rsp_write", longint'(rsp_write), longint'(m_wr));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    // issue one request and measure its latency in edges from acceptance
    task automatic do_req(input logic [AW-1:0] a, input logic wr,
                          input int exp_lat, input string tag);
        int lat;
        while (!req_ready) tick();
        req_addr  = a;
        req_write = wr;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 50) begin
            tick();
            lat++;
        end
        chk(tag, longint'(lat), longint'(exp_lat));
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 ready after reset", longint'(req_ready), 1);
        chk("R2 rsp_valid after reset", longint'(rsp_valid), 0);
        chk("R2 counters after reset", longint'(conflict_cnt + cycle_cnt + byte_cnt), 0);

        // sequential stream in page 0, then across the boundary
        do_req(32'd0,  1'b0, TR, "R2 first access latency");
        chk("R2 no conflict on first access", longint'(conflict_cnt), 0);
        do_req(32'd1,  1'b1, TP, "R4 R10 same-page write latency");
        do_req(32'd2,  1'b0, TP, "R4 same-page latency");
        do_req(32'd63, 1'b1, TP, "R4 last word of page");
        do_req(32'd64, 1'b0, TR, "R3 boundary crossing latency");
        do_req(32'd65, 1'b0, TP, "R4 hit in new page");
        // alternating pages
        do_req(32'd0,  1'b1, TR, "R3 alternate page 0");
        do_req(32'd64, 1'b0, TR, "R3 alternate page 1");
        do_req(32'd0,  1'b0, TR, "R3 alternate page 0");
        do_req(32'd64, 1'b1, TR, "R3 alternate page 1");
        chk("R5 conflict total", longint'(conflict_cnt), 5);
        chk("R7 cycle total", longint'(cycle_cnt), 60);
        chk("R8 byte total", longint'(byte_cnt), 40);

        // clear keeps the open page
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk("R9 counters cleared", longint'(conflict_cnt + cycle_cnt + byte_cnt), 0);
        do_req(32'd100, 1'b0, TP, "R9 open page kept across clear");
        chk("R9 no conflict after clear", longint'(conflict_cnt), 0);

        // only the top bit differs
        do_req(32'h8000_0040, 1'b1, TR, "R1 upper address bit changes page");
        chk("R1 conflict on upper bit", longint'(conflict_cnt), 1);

        // clear on the same edge as a conflicting acceptance
        while (!req_ready) tick();
        req_addr  = 32'd0;
        req_write = 1'b0;
        req_valid = 1'b1;
        clr       = 1'b1;
        tick();
        req_valid = 1'b0;
        clr       = 1'b0;
        chk("R9 clear overrides conflict", longint'(conflict_cnt), 0);
        repeat (TR + 1) tick();
        chk("R7 cycles after clear", longint'(cycle_cnt), TR);
        chk("R8 bytes after clear", longint'(byte_cnt), 4);

        // held request: back-to-back same-page accesses
        req_addr  = 32'd5;
        req_write = 1'b1;
        req_valid = 1'b1;
        repeat (40) tick();
        req_valid = 1'b0;
        repeat (12) tick();
        chk("R6 back-to-back accesses served", longint'(byte_cnt), 4 + 8 * 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule